// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet port, between the line side and the host-side buffer. It reads the first six bytes of each frame, which form the destination address. It then decides whether this station wants the frame. Only frames that pass are forwarded toward the host, so unwanted traffic costs no bus cycles and raises no interrupt.

A frame passes when any of these holds:

- its destination equals the programmed station address;
- the destination is the all-ones broadcast address;
- the destination is a group address whose hash selects a set bit in a 64-entry table;
- promiscuous mode is on.

Group filtering is by hash, so two different group addresses can share one table bit. The host may therefore still receive some group traffic it did not ask for.

Each frame's six address bytes are held in a small internal store until the verdict is known. The verdict appears on a one-cycle decision strobe. An accepted frame then leaves on the output stream with its first six bytes replayed from the store, followed by the rest of the frame cut through from the input. A rejected frame is consumed and discarded with no output.

Both streams use valid/ready. A byte moves when valid and ready are both high at a rising clock edge. A sender holding valid high with ready low must keep data, start and end flags stable. The filter obeys this rule on its output. While it cuts a frame through, its input ready follows the output ready. While it collects or discards bytes, its input ready stays high. During the decision cycle and while replaying stored bytes, its input ready is low.

The configuration registers are written through a plain write port. A write lands in a staging copy. The copy that is used for filtering takes the staged values at each frame's first byte.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `s_ready` is high, and `m_valid` and `dec_valid` are low. The station address, hash table and promiscuous bit all reset to zero.
- R2: A frame whose six destination bytes equal the station address is accepted and forwarded unchanged. `m_sof` marks its first byte and `m_eof` its last. The first byte on the wire is compared with bits 15:8 of register 1, the second with bits 7:0 of register 1, and bytes three to six with bits 31:24 down to 7:0 of register 0.
- R3: A frame whose destination is all ones is accepted, whatever the configuration.
- R4: A destination whose first byte has bit 0 set is a group address. Its table index is bits 5:0 of a CRC-32 taken over the six bytes in wire order. The CRC uses the reflected polynomial 0xEDB88320, takes each byte least significant bit first, starts at all ones and has no final inversion. The frame is accepted when that table entry is 1. Register 2 holds entries 0 to 31 and register 3 holds entries 32 to 63, with entry 32k+j in bit j.
- R5: A frame that matches no rule produces one decision with accept low. None of its bytes appear on the output, and all of its bytes are consumed.
- R6: Two different group addresses with the same table index are both accepted when that one entry is set.
- R7: When bit 0 of register 4 is set, every frame of at least six bytes is accepted.
- R8: `dec_valid` rises for exactly one cycle, in the cycle after the sixth byte is taken. While it is high, `s_ready` is low. No output byte appears before it.
- R9: A configuration write takes effect from the first frame that starts after the write. This includes a write in the same cycle as a start byte, and a write part-way through a frame's address bytes; neither changes that frame's verdict.
- R10: A frame that ends before its sixth byte is dropped. Its single decision, with accept low, comes in the cycle after its last byte.
- R11: While `m_valid` is high and `m_ready` is low, the output byte and its flags stay stable. A frame forwarded under stalls arrives intact.
- R12: Bytes that arrive outside a frame, before any start marker, are consumed and ignored. They produce no decision and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Filter can take an input byte |
| s_data | input | 8 | Input byte |
| s_sof | input | 1 | Input byte is the first of a frame |
| s_eof | input | 1 | Input byte is the last of a frame |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Host side can take an output byte |
| m_data | output | 8 | Output byte |
| m_sof | output | 1 | Output byte is the first of a frame |
| m_eof | output | 1 | Output byte is the last of a frame |
| dec_valid | output | 1 | One-cycle verdict strobe, one per frame |
| dec_accept | output | 1 | Verdict: 1 forward, 0 drop |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Register select: 0,1 station; 2,3 hash table; 4 control |
| cfg_wdata | input | 32 | Configuration write data |

## Verification
A configuration write and the sampling of that configuration for a frame can fall in the same cycle. This happens when the write strobe coincides with a start byte, and again when it coincides with the third address byte of a frame. In each case the bench rewrites the station address to equal the frame's own destination. It judges the collision as correct when that frame is still dropped and an identical frame sent next is accepted. Replay from the store and output stalls also meet during flush, and they are exercised with a periodic `m_ready` pattern.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int BYTE_W     = 8;
  localparam int DA_BYTES   = 6;
  localparam int DA_W       = DA_BYTES * BYTE_W;
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    GS_IDLE,
    GS_COLLECT,
    GS_DECIDE,
    GS_FLUSH,
    GS_PASS,
    GS_DISCARD
  } gate_state_e;

  // One byte of reflected CRC-32, least significant bit of the byte first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxf_cfg.sv
module rxf_cfg
  import rxf_pkg::*;
#(
  parameter int HASH_IDX_W = 6,
  parameter int CFG_AW     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [CFG_AW-1:0]           cfg_addr,
  input  logic [31:0]                 cfg_wdata,
  input  logic                        commit,
  output logic [DA_W-1:0]             act_station,
  output logic [(1<<HASH_IDX_W)-1:0]  act_hash,
  output logic                        act_promisc
);

  localparam int HASH_N     = 1 << HASH_IDX_W;
  localparam int HASH_WORDS = HASH_N / 32;
  localparam int CTRL_ADDR  = 2 + HASH_WORDS;

  logic [DA_W-1:0]   stg_station;
  logic [HASH_N-1:0] stg_hash;
  logic              stg_promisc;

  // Staging copy: written at any time.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_station <= '0;
      stg_hash    <= '0;
      stg_promisc <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(0)) stg_station[31:0]  <= cfg_wdata;
      if (cfg_addr == CFG_AW'(1)) stg_station[47:32] <= cfg_wdata[15:0];
      for (int w = 0; w < HASH_WORDS; w++) begin
        if (cfg_addr == CFG_AW'(2 + w)) stg_hash[w*32 +: 32] <= cfg_wdata;
      end
      if (cfg_addr == CFG_AW'(CTRL_ADDR)) stg_promisc <= cfg_wdata[0];
    end
  end

  // Working copy: refreshed only at a frame's first byte.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_station <= '0;
      act_hash    <= '0;
      act_promisc <= 1'b0;
    end else if (commit) begin
      act_station <= stg_station;
      act_hash    <= stg_hash;
      act_promisc <= stg_promisc;
    end
  end

endmodule

// File: rtl/rxf_dest_capture.sv
module rxf_dest_capture
  import rxf_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] data,
  output logic [DA_W-1:0]   da,
  output logic [CRC_W-1:0]  crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      da  <= '0;
      crc <= CRC_SEED;
    end else if (take) begin
      if (first) begin
        da  <= {data, {(DA_W-BYTE_W){1'b0}}};
        crc <= crc_step(CRC_SEED, data);
      end else begin
        for (int i = 1; i < DA_BYTES; i++) begin
          if (idx == IDX_W'(i)) da[(DA_BYTES-1-i)*BYTE_W +: BYTE_W] <= data;
        end
        crc <= crc_step(crc, data);
      end
    end
  end

endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
#(
  parameter int HASH_IDX_W = 6
) (
  input  logic [DA_W-1:0]             da,
  input  logic [CRC_W-1:0]            crc,
  input  logic                        hdr_full,
  input  logic [DA_W-1:0]             station,
  input  logic [(1<<HASH_IDX_W)-1:0]  hash,
  input  logic                        promisc,
  output logic                        accept
);

  logic                  is_bcast;
  logic                  is_group;
  logic                  is_self;
  logic                  hash_hit;
  logic [HASH_IDX_W-1:0] hidx;

  always_comb begin
    is_bcast = &da;
    is_group = da[DA_W-BYTE_W];
    is_self  = (da == station);
    hidx     = crc[HASH_IDX_W-1:0];
    hash_hit = hash[hidx];
    accept   = hdr_full & (promisc | is_bcast | is_self | (is_group & hash_hit));
  end

endmodule

// File: rtl/rxf_gate.sv
module rxf_gate
  import rxf_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int IDX_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_sof,
  input  logic              s_eof,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_sof,
  output logic              m_eof,
  input  logic              accept,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic              cap_take,
  output logic              cap_first,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              hdr_full,
  output logic              commit
);

  localparam logic [IDX_W-1:0] FULL_CNT = IDX_W'(DEPTH);

  gate_state_e       state;
  logic [BYTE_W-1:0] hold [DEPTH];
  logic [IDX_W-1:0]  cnt;
  logic [IDX_W-1:0]  rd;
  logic              last_eof;
  logic              in_fire;
  logic [IDX_W-1:0]  wr;
  logic [IDX_W-1:0]  wr_nxt;
  logic              in_frame_start;

  always_comb begin
    unique case (state)
      GS_IDLE, GS_COLLECT, GS_DISCARD: s_ready = 1'b1;
      GS_PASS:                         s_ready = m_ready;
      default:                         s_ready = 1'b0;
    endcase
  end

  assign in_fire        = s_valid & s_ready;
  assign in_frame_start = in_fire & s_sof & ((state == GS_IDLE) | (state == GS_COLLECT));
  assign cap_first      = in_frame_start;
  assign cap_take       = in_frame_start | (in_fire & (state == GS_COLLECT));
  assign wr             = cap_first ? '0 : cnt;
  assign wr_nxt         = wr + 1'b1;
  assign cap_idx        = wr;
  assign commit         = in_frame_start;
  assign hdr_full       = (cnt == FULL_CNT);
  assign dec_valid      = (state == GS_DECIDE);
  assign dec_accept     = (state == GS_DECIDE) & accept;

  always_comb begin
    m_valid = 1'b0;
    m_data  = '0;
    m_sof   = 1'b0;
    m_eof   = 1'b0;
    if (state == GS_FLUSH) begin
      m_valid = 1'b1;
      m_data  = hold[rd];
      m_sof   = (rd == '0);
      m_eof   = last_eof & (rd == cnt - 1'b1);
    end else if (state == GS_PASS) begin
      m_valid = s_valid;
      m_data  = s_data;
      m_eof   = s_eof;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_take) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr == IDX_W'(i)) hold[i] <= s_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= GS_IDLE;
      cnt      <= '0;
      rd       <= '0;
      last_eof <= 1'b0;
    end else begin
      unique case (state)
        GS_IDLE, GS_COLLECT: begin
          if (cap_take) begin
            cnt      <= wr_nxt;
            last_eof <= s_eof;
            if (s_eof || wr_nxt == FULL_CNT) state <= GS_DECIDE;
            else                             state <= GS_COLLECT;
          end
        end
        GS_DECIDE: begin
          rd <= '0;
          if (accept)        state <= GS_FLUSH;
          else if (last_eof) state <= GS_IDLE;
          else               state <= GS_DISCARD;
        end
        GS_FLUSH: begin
          if (m_ready) begin
            rd <= rd + 1'b1;
            if (rd == cnt - 1'b1) state <= last_eof ? GS_IDLE : GS_PASS;
          end
        end
        GS_PASS, GS_DISCARD: begin
          if (in_fire && s_eof) state <= GS_IDLE;
        end
        default: state <= GS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int HASH_IDX_W = 6,
  parameter int CFG_AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_sof,
  input  logic              s_eof,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [7:0]        m_data,
  output logic              m_sof,
  output logic              m_eof,
  output logic              dec_valid,
  output logic              dec_accept,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata
);

  localparam int HASH_N = 1 << HASH_IDX_W;
  localparam int IDX_W  = $clog2(DA_BYTES + 1);

  logic [DA_W-1:0]   act_station;
  logic [HASH_N-1:0] act_hash;
  logic              act_promisc;
  logic              commit;
  logic              cap_take;
  logic              cap_first;
  logic [IDX_W-1:0]  cap_idx;
  logic [DA_W-1:0]   da_q;
  logic [CRC_W-1:0]  crc_q;
  logic              hdr_full;
  logic              accept;

  rxf_cfg #(.HASH_IDX_W(HASH_IDX_W), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .commit(commit), .act_station(act_station),
    .act_hash(act_hash), .act_promisc(act_promisc)
  );

  rxf_dest_capture #(.IDX_W(IDX_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(cap_take), .first(cap_first),
    .idx(cap_idx), .data(s_data), .da(da_q), .crc(crc_q)
  );

  rxf_classify #(.HASH_IDX_W(HASH_IDX_W)) u_cls (
    .da(da_q), .crc(crc_q), .hdr_full(hdr_full), .station(act_station),
    .hash(act_hash), .promisc(act_promisc), .accept(accept)
  );

  rxf_gate #(.DEPTH(DA_BYTES), .IDX_W(IDX_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sof(m_sof), .m_eof(m_eof),
    .accept(accept), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .cap_take(cap_take), .cap_first(cap_first), .cap_idx(cap_idx),
    .hdr_full(hdr_full), .commit(commit)
  );

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        s_ready,
  input logic        m_valid,
  input logic        m_ready,
  input logic [7:0]  m_data,
  input logic        m_sof,
  input logic        m_eof,
  input logic        dec_valid,
  input logic        dec_accept,
  input logic [47:0] da,
  input logic [47:0] station,
  input logic        hdr_full
);

  AST_DEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R8

  AST_HOLD_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (!s_ready && !m_valid)); // R8

  AST_BCAST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && (&da)) |-> dec_accept); // R3

  AST_SELF_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && hdr_full && da == station) |-> dec_accept); // R2

  AST_FLUSH_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_accept) |=> (m_valid && m_sof)); // R2

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_accept) |=> !m_valid); // R5

  AST_RUNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !hdr_full) |-> !dec_accept); // R10

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sof) && $stable(m_eof))); // R11

endmodule

bind rx_addr_filter rxf_checker u_rxf_checker (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_sof(m_sof), .m_eof(m_eof), .dec_valid(dec_valid),
  .dec_accept(dec_accept), .da(da_q), .station(act_station), .hdr_full(hdr_full)
);

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        s_sof = 1'b0;
  logic        s_eof = 1'b0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [7:0]  m_data;
  logic        m_sof;
  logic        m_eof;
  logic        dec_valid;
  logic        dec_accept;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;

  always #2.5 clk = ~clk;

  rx_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sof(s_sof), .s_eof(s_eof), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_sof(m_sof), .m_eof(m_eof), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int cyc = 0;
  bit stall_on = 0;

  logic [7:0] fb [64];
  int flen;
  logic [7:0] ob [64];
  bit osof [64];
  bit oeof [64];
  int out_n, dec_n, dec_cyc, hold_err;
  bit dec_acc, early;
  int acc6_cyc, eof_cyc;
  int wr_idx = -1;
  logic [3:0] wr_a;
  logic [31:0] wr_d;
  logic [63:0] hmirror = '0;
  bit pv, pr, ps, pe;
  logic [7:0] pd;

  // Monitor: drives m_ready at the falling edge, samples 2 ns later.
  always begin
    @(negedge clk);
    cyc++;
    m_ready = stall_on ? ((cyc % 3) != 1) : 1'b1;
    #2;
    if (rst_n) begin
      if (pv && !pr) begin
        if (!(m_valid && m_data == pd && m_sof == ps && m_eof == pe)) hold_err++;
      end
      if (dec_valid) begin
        dec_n++;
        dec_acc = dec_accept;
        dec_cyc = cyc;
      end
      if (m_valid && dec_n == 0) early = 1;
      if (m_valid && m_ready && out_n < 64) begin
        ob[out_n] = m_data; osof[out_n] = m_sof; oeof[out_n] = m_eof;
        out_n++;
      end
      pv = m_valid; pr = m_ready; pd = m_data; ps = m_sof; pe = m_eof;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] byt = a[47-8*b -: 8];
      for (int k = 0; k < 8; k++) begin
        bit t = c[0] ^ byt[k];
        c = {1'b0, c[31:1]};
        if (t) c = c ^ 32'hEDB8_8320;
      end
    end
    return c;
  endfunction

  function automatic int hidx(input logic [47:0] a);
    logic [31:0] c = ref_crc(a);
    return int'(c[5:0]);
  endfunction

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_station(input logic [47:0] s);
    cfg_write(4'd0, s[31:0]);
    cfg_write(4'd1, {16'h0, s[47:32]});
  endtask

  task automatic set_hash_bit(input int i, input bit v);
    hmirror[i] = v;
    cfg_write(4'd2, hmirror[31:0]);
    cfg_write(4'd3, hmirror[63:32]);
  endtask

  task automatic push(input logic [7:0] d, input bit sof, input bit eof, input int idx);
    @(negedge clk);
    s_valid = 1; s_data = d; s_sof = sof; s_eof = eof;
    cfg_we = 0;
    if (idx == wr_idx) begin cfg_we = 1; cfg_addr = wr_a; cfg_wdata = wr_d; end
    #1;
    while (!s_ready) begin
      @(negedge clk);
      cfg_we = 0;
      #1;
    end
    if (idx == 5) acc6_cyc = cyc;
    if (eof) eof_cyc = cyc;
  endtask

  task automatic go_idle();
    @(negedge clk);
    s_valid = 0; s_sof = 0; s_eof = 0; cfg_we = 0;
  endtask

  task automatic build(input logic [47:0] dst, input int len);
    flen = len;
    for (int i = 0; i < 64; i++) fb[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 6; i++) fb[i] = dst[47-8*i -: 8];
  endtask

  task automatic send_frame();
    out_n = 0; dec_n = 0; early = 0; hold_err = 0; dec_acc = 0;
    for (int i = 0; i < flen; i++) push(fb[i], i == 0, i == flen - 1, i);
    go_idle();
    wr_idx = -1;
    repeat (40) @(negedge clk);
  endtask

  task automatic judge(input string req, input bit exp_acc);
    int mism = 0;
    chk(dec_n == 1, req, dec_n, 1);
    chk(dec_acc == exp_acc, req, dec_acc, exp_acc);
    if (exp_acc) begin
      chk(out_n == flen, req, out_n, flen);
      for (int i = 0; i < flen; i++) if (ob[i] != fb[i]) mism++;
      chk(mism == 0, req, mism, 0);
      chk(osof[0] && oeof[flen-1], req, {osof[0], oeof[flen-1]}, 2'b11);
    end else begin
      chk(out_n == 0, req, out_n, 0);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(s_ready == 1 && m_valid == 0 && dec_valid == 0, "R1", {s_ready, m_valid, dec_valid}, 3'b100);
  endtask

  task automatic t_unicast();
    set_station(48'h02_11_22_33_44_55);
    build(48'h02_11_22_33_44_55, 16);
    send_frame();
    judge("R2", 1);
    chk(dec_cyc == acc6_cyc + 1, "R8 timing", dec_cyc, acc6_cyc + 1);
    chk(!early, "R8 holdback", early, 0);
  endtask

  task automatic t_unicast_miss();
    build(48'h02_11_22_33_44_56, 16);
    send_frame();
    judge("R5 unicast", 0);
  endtask

  task automatic t_broadcast();
    build(48'hFF_FF_FF_FF_FF_FF, 12);
    send_frame();
    judge("R3", 1);
  endtask

  task automatic t_group();
    logic [47:0] g1 = 48'h01_00_5E_00_00_01;
    logic [47:0] g2 = '0, g3 = '0;
    bit f2 = 0, f3 = 0;
    int i1 = hidx(g1);
    for (int k = 0; k < 256; k++) begin
      logic [47:0] c = {40'h01_00_5E_00_01, 8'(k)};
      if (!f2 && hidx(c) == i1) begin g2 = c; f2 = 1; end
      if (!f3 && hidx(c) != i1) begin g3 = c; f3 = 1; end
    end
    set_hash_bit(i1, 1);
    build(g1, 14); send_frame(); judge("R4", 1);
    build(g3, 14); send_frame(); judge("R5 group", 0);
    chk(f2, "R6 search", f2, 1);
    build(g2, 14); send_frame(); judge("R6", 1);
    set_hash_bit(i1, 0);
    build(g1, 14); send_frame(); judge("R4 cleared", 0);
  endtask

  task automatic t_promisc();
    cfg_write(4'd4, 32'h1);
    build(48'h0A_0B_0C_0D_0E_0F, 10); send_frame(); judge("R7", 1);
    cfg_write(4'd4, 32'h0);
    build(48'h0A_0B_0C_0D_0E_0F, 10); send_frame(); judge("R7 off", 0);
  endtask

  task automatic t_cfg_boundary();
    wr_idx = 0; wr_a = 4'd0; wr_d = 32'hAABB_CCDD;
    build(48'h02_11_AA_BB_CC_DD, 10); send_frame(); judge("R9 sof write", 0);
    build(48'h02_11_AA_BB_CC_DD, 10); send_frame(); judge("R9 next frame", 1);
    wr_idx = 2; wr_a = 4'd0; wr_d = 32'h3344_5566;
    build(48'h02_11_33_44_55_66, 10); send_frame(); judge("R9 mid write", 0);
    build(48'h02_11_33_44_55_66, 10); send_frame(); judge("R9 after mid", 1);
  endtask

  task automatic t_runt();
    build(48'hFF_FF_FF_FF_FF_FF, 4); send_frame();
    judge("R10", 0);
    chk(dec_cyc == eof_cyc + 1, "R10 timing", dec_cyc, eof_cyc + 1);
  endtask

  task automatic t_backpressure();
    stall_on = 1;
    build(48'hFF_FF_FF_FF_FF_FF, 24); send_frame();
    stall_on = 0;
    judge("R11", 1);
    chk(hold_err == 0, "R11 stable", hold_err, 0);
  endtask

  task automatic t_stray();
    out_n = 0; dec_n = 0;
    push(8'h55, 0, 0, 99); push(8'h66, 0, 0, 99); push(8'h77, 0, 1, 99);
    go_idle();
    repeat (10) @(negedge clk);
    chk(dec_n == 0 && out_n == 0, "R12", {dec_n[15:0], out_n[15:0]}, 0);
    build(48'hFF_FF_FF_FF_FF_FF, 8); send_frame(); judge("R12 after", 1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_unicast();
    t_unicast_miss();
    t_broadcast();
    t_group();
    t_promisc();
    t_cfg_boundary();
    t_runt();
    t_backpressure();
    t_stray();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule